// File: doc/BRIEF.md
# Segmented Packet Bus Framing Monitor

This block is a passive observer on a wide packet bus that is made of four parallel segments. Each segment is sixteen bytes wide. In every clock cycle, each segment presents an enable, a start marker, an end marker, an error marker and a 4-bit count of unused bytes. The monitor never drives the bus. The data lanes carry no framing information, so they are not brought into the block. The monitor reads only the control fields of each segment.

Within a cycle the segments are walked from segment 0 up to the last segment. The "packet open" state passes from each segment to the next, and from the last segment to segment 0 of the following cycle. Because of this, several packets can start and finish inside one clock. Framing faults set sticky flags. Three counters track completed clean packets, completed errored packets and the total payload bytes. A clear input zeroes the three counters.

Top module: `seg_bus_monitor`

## Requirements
- R1: After reset, every violation flag, every counter and the internal packet-open state are zero.
- R2: A segment whose enable is 0 has no effect on any output, whatever its start, end, error and empty fields hold.
- R3: An enabled segment with start=0, seen while no packet is open, sets `viol_orphan`. That transfer adds nothing to any counter.
- R4: An enabled segment with start=1, seen while a packet is already open, sets `viol_dup_sop`. The open packet is dropped without a packet count, but its bytes already counted stay counted. The new packet then begins at this segment.
- R5: An enabled segment whose lower-numbered neighbour is idle in the same cycle sets `viol_gap`. The segment is still processed for framing and counting.
- R6: The violation flags are sticky. Only reset clears them, and `cnt_clr` leaves them unchanged.
- R7: Segments are evaluated in ascending index order within a cycle. The open state carries across segments and across cycles, so up to four packets may complete in one cycle.
- R8: Each accepted transfer with end=1 completes a packet. It adds one to `good_pkts` when its error bit is 0, and one to `bad_pkts` when its error bit is 1.
- R9: `byte_total` grows by 16 for each accepted transfer with end=0. For each accepted transfer with end=1 it grows by 16 minus the empty count (empty field bits [3:0] of that segment, at `seg_mty[4s+3:4s]`).
- R10: On an accepted final transfer that has error=1, empty bits [2:0] count as zero. The transfer therefore adds 16 bytes when empty bit 3 is 0, and 8 bytes when empty bit 3 is 1.
- R11: `cnt_clr`=1 zeroes all three counters at the next edge. It takes precedence over any transfer in the same cycle.
- R12: Flags and counters reflect a cycle's transfers right after the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Synchronous clear of the three counters |
| seg_ena | input | 4 | Per-segment transfer enable, bit s for segment s |
| seg_sop | input | 4 | Per-segment start-of-packet marker |
| seg_eop | input | 4 | Per-segment end-of-packet marker |
| seg_err | input | 4 | Per-segment error marker, meaningful with end=1 |
| seg_mty | input | 16 | Per-segment empty-byte count, segment s at bits [4s+3:4s] |
| viol_orphan | output | 1 | Sticky: transfer seen with no packet open and no start marker |
| viol_dup_sop | output | 1 | Sticky: start marker seen inside an open packet |
| viol_gap | output | 1 | Sticky: idle segment below an enabled one |
| good_pkts | output | 32 | Count of packets ended without error |
| bad_pkts | output | 32 | Count of packets ended with error |
| byte_total | output | 32 | Count of valid payload bytes in accepted transfers |

## Verification
The assertions assume that `cnt_clr` and the segment fields are stable at each rising edge, and that the counters do not wrap within a run. The bound on per-cycle byte growth holds only between clears. The bench changes inputs only on falling edges and keeps totals far below the counter range. Each scenario starts from a known state, using a reset pulse or a counter clear, so every expected value is a closed sum that is worked out from the requirements.

// File: rtl/segmon_pkg.sv
package segmon_pkg;
  localparam int SEG_BYTES = 16;
  localparam int MTY_W     = $clog2(SEG_BYTES);

  // Empty count after the error mask: low bits forced to zero when err=1.
  function automatic logic [MTY_W-1:0] eff_empty(input logic err,
                                                 input logic [MTY_W-1:0] mty);
    return err ? {mty[MTY_W-1], {(MTY_W-1){1'b0}}} : mty;
  endfunction

  // Valid bytes carried by one accepted transfer.
  function automatic logic [MTY_W:0] xfer_bytes(input logic eop,
                                                input logic err,
                                                input logic [MTY_W-1:0] mty);
    if (!eop) return (MTY_W+1)'(SEG_BYTES);
    return (MTY_W+1)'(SEG_BYTES) - {1'b0, eff_empty(err, mty)};
  endfunction
endpackage

// File: rtl/segmon_frame.sv
module segmon_frame
  import segmon_pkg::*;
#(
  parameter int NSEG   = 4,
  parameter int PKT_W  = $clog2(NSEG + 1),
  parameter int BYTE_W = $clog2(NSEG * SEG_BYTES + 1)
) (
  input  logic                  open_q,
  input  logic [NSEG-1:0]       ena,
  input  logic [NSEG-1:0]       sop,
  input  logic [NSEG-1:0]       eop,
  input  logic [NSEG-1:0]       err,
  input  logic [NSEG*MTY_W-1:0] mty,
  output logic                  open_d,
  output logic [PKT_W-1:0]      cyc_good,
  output logic [PKT_W-1:0]      cyc_bad,
  output logic [BYTE_W-1:0]     cyc_bytes,
  output logic                  ev_orphan,
  output logic                  ev_dup,
  output logic                  ev_gap
);
  logic [NSEG:0]   open_c;
  logic [NSEG-1:0] acc, orph, dup, gap, good_v, bad_v;
  logic [MTY_W:0]  bytes_v [NSEG];

  assign open_c[0] = open_q;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign acc[s]    = ena[s] & (sop[s] | open_c[s]);
    assign orph[s]   = ena[s] & ~sop[s] & ~open_c[s];
    assign dup[s]    = ena[s] & sop[s] & open_c[s];
    assign open_c[s+1] = acc[s] ? ~eop[s] : open_c[s];
    assign good_v[s] = acc[s] & eop[s] & ~err[s];
    assign bad_v[s]  = acc[s] & eop[s] & err[s];
    assign bytes_v[s] = acc[s] ? xfer_bytes(eop[s], err[s], mty[s*MTY_W +: MTY_W])
                               : '0;
    if (s == 0) begin : g_first
      assign gap[s] = 1'b0;
    end else begin : g_rest
      assign gap[s] = ena[s] & ~ena[s-1];
    end
  end

  always_comb begin
    cyc_good  = '0;
    cyc_bad   = '0;
    cyc_bytes = '0;
    for (int s = 0; s < NSEG; s++) begin
      cyc_good  = cyc_good + PKT_W'(good_v[s]);
      cyc_bad   = cyc_bad + PKT_W'(bad_v[s]);
      cyc_bytes = cyc_bytes + BYTE_W'(bytes_v[s]);
    end
  end

  assign open_d    = open_c[NSEG];
  assign ev_orphan = |orph;
  assign ev_dup    = |dup;
  assign ev_gap    = |gap;
endmodule

// File: rtl/segmon_count.sv
module segmon_count #(
  parameter int CNT_W  = 32,
  parameter int PKT_W  = 3,
  parameter int BYTE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [PKT_W-1:0]  inc_good,
  input  logic [PKT_W-1:0]  inc_bad,
  input  logic [BYTE_W-1:0] inc_bytes,
  output logic [CNT_W-1:0]  good_q,
  output logic [CNT_W-1:0]  bad_q,
  output logic [CNT_W-1:0]  bytes_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q  <= '0;
      bad_q   <= '0;
      bytes_q <= '0;
    end else if (clr) begin
      good_q  <= '0;
      bad_q   <= '0;
      bytes_q <= '0;
    end else begin
      good_q  <= good_q + CNT_W'(inc_good);
      bad_q   <= bad_q + CNT_W'(inc_bad);
      bytes_q <= bytes_q + CNT_W'(inc_bytes);
    end
  end
endmodule

// File: rtl/seg_bus_monitor.sv
module seg_bus_monitor
  import segmon_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cnt_clr,
  input  logic [NSEG-1:0]       seg_ena,
  input  logic [NSEG-1:0]       seg_sop,
  input  logic [NSEG-1:0]       seg_eop,
  input  logic [NSEG-1:0]       seg_err,
  input  logic [NSEG*MTY_W-1:0] seg_mty,
  output logic                  viol_orphan,
  output logic                  viol_dup_sop,
  output logic                  viol_gap,
  output logic [CNT_W-1:0]      good_pkts,
  output logic [CNT_W-1:0]      bad_pkts,
  output logic [CNT_W-1:0]      byte_total
);
  localparam int PKT_W  = $clog2(NSEG + 1);
  localparam int BYTE_W = $clog2(NSEG * SEG_BYTES + 1);

  logic              open_q, open_d;
  logic [PKT_W-1:0]  cyc_good, cyc_bad;
  logic [BYTE_W-1:0] cyc_bytes;
  logic              ev_orphan, ev_dup, ev_gap;

  segmon_frame #(.NSEG(NSEG), .PKT_W(PKT_W), .BYTE_W(BYTE_W)) u_frame (
    .open_q    (open_q),
    .ena       (seg_ena),
    .sop       (seg_sop),
    .eop       (seg_eop),
    .err       (seg_err),
    .mty       (seg_mty),
    .open_d    (open_d),
    .cyc_good  (cyc_good),
    .cyc_bad   (cyc_bad),
    .cyc_bytes (cyc_bytes),
    .ev_orphan (ev_orphan),
    .ev_dup    (ev_dup),
    .ev_gap    (ev_gap)
  );

  segmon_count #(.CNT_W(CNT_W), .PKT_W(PKT_W), .BYTE_W(BYTE_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .inc_good  (cyc_good),
    .inc_bad   (cyc_bad),
    .inc_bytes (cyc_bytes),
    .good_q    (good_pkts),
    .bad_q     (bad_pkts),
    .bytes_q   (byte_total)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q       <= 1'b0;
      viol_orphan  <= 1'b0;
      viol_dup_sop <= 1'b0;
      viol_gap     <= 1'b0;
    end else begin
      open_q       <= open_d;
      viol_orphan  <= viol_orphan | ev_orphan;
      viol_dup_sop <= viol_dup_sop | ev_dup;
      viol_gap     <= viol_gap | ev_gap;
    end
  end
endmodule

// File: rtl/segmon_checker.sv
module segmon_checker #(
  parameter int NSEG  = 4,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_clr,
  input logic [NSEG-1:0]  seg_ena,
  input logic             ev_gap,
  input logic             viol_orphan,
  input logic             viol_dup_sop,
  input logic             viol_gap,
  input logic [CNT_W-1:0] good_pkts,
  input logic [CNT_W-1:0] bad_pkts,
  input logic [CNT_W-1:0] byte_total
);
  // R6: sticky flags never fall while out of reset
  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_orphan || viol_dup_sop || viol_gap) |=>
      ((viol_orphan >= $past(viol_orphan)) && (viol_dup_sop >= $past(viol_dup_sop))
       && (viol_gap >= $past(viol_gap))));

  // R5: a packing hole seen by the framing logic shows on the flag next cycle
  a_r5_gap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gap |=> viol_gap);

  // R11: clear zeroes every counter
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (good_pkts == '0 && bad_pkts == '0 && byte_total == '0));

  // R2: an all-idle cycle leaves the counters untouched
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_ena == '0 && !cnt_clr) |=>
      ($stable(good_pkts) && $stable(bad_pkts) && $stable(byte_total)));

  // R9: bytes grow by at most a full bus width per cycle
  a_r9_byte_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> ((byte_total - $past(byte_total)) <= CNT_W'(NSEG * 16)));

  // R8: at most one packet completion per segment per cycle
  a_r8_pkt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (((good_pkts - $past(good_pkts)) + (bad_pkts - $past(bad_pkts)))
                  <= CNT_W'(NSEG)));
endmodule

bind seg_bus_monitor segmon_checker #(.NSEG(NSEG), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_clr      (cnt_clr),
  .seg_ena      (seg_ena),
  .ev_gap       (ev_gap),
  .viol_orphan  (viol_orphan),
  .viol_dup_sop (viol_dup_sop),
  .viol_gap     (viol_gap),
  .good_pkts    (good_pkts),
  .bad_pkts     (bad_pkts),
  .byte_total   (byte_total)
);

// File: tb/seg_bus_monitor_tb.sv
module seg_bus_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_clr = 1'b0;
  logic [3:0]  ena = '0, sop = '0, eop = '0, err = '0;
  logic [15:0] mty = '0;
  logic        v_orph, v_dup, v_gap;
  logic [31:0] good, bad, bytes;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  seg_bus_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr),
    .seg_ena(ena), .seg_sop(sop), .seg_eop(eop), .seg_err(err), .seg_mty(mty),
    .viol_orphan(v_orph), .viol_dup_sop(v_dup), .viol_gap(v_gap),
    .good_pkts(good), .bad_pkts(bad), .byte_total(bytes)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // apply one cycle of stimulus at a falling edge, return at the next falling edge
  task automatic put(input logic [3:0] e, input logic [3:0] s, input logic [3:0] p,
                     input logic [3:0] r, input logic [15:0] m, input logic c);
    ena = e; sop = s; eop = p; err = r; mty = m; cnt_clr = c;
    @(negedge clk);
    ena = '0; sop = '0; eop = '0; err = '0; mty = '0; cnt_clr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 good", good, 0); check("R1 bad", bad, 0); check("R1 bytes", bytes, 0);
    check("R1 flags", {v_orph, v_dup, v_gap}, 0);
  endtask

  task automatic t_four_in_one();
    do_reset();
    // four single-transfer packets, empty 0,1,5,15
    put(4'hF, 4'hF, 4'hF, 4'h0, 16'hF510, 1'b0);
    check("R7 four pkts good", good, 4);
    check("R9 bytes 16+15+11+1", bytes, 43);
    check("R7 no flags", {v_orph, v_dup, v_gap}, 0);
  endtask

  task automatic t_cross_cycle();
    do_reset();
    put(4'hF, 4'h1, 4'h0, 4'h0, 16'h0000, 1'b0);
    check("R12 no pkt yet", good, 0);
    check("R12 bytes after cycle", bytes, 64);
    // seg0 ends carried packet (empty 3), seg1 is a whole packet
    put(4'h3, 4'h2, 4'h3, 4'h0, 16'h0003, 1'b0);
    check("R7 carried packets", good, 2);
    check("R9 bytes 64+13+16", bytes, 93);
    check("R7 no flags", {v_orph, v_dup, v_gap}, 0);
  endtask

  task automatic t_err_mask();
    do_reset();
    // seg0 err empty 0111 -> 16 bytes, seg1 err empty 1101 -> 8 bytes
    put(4'h3, 4'h3, 4'h3, 4'h3, 16'h00D7, 1'b0);
    check("R8 bad count", bad, 2);
    check("R8 good count", good, 0);
    check("R10 masked bytes", bytes, 24);
  endtask

  task automatic t_idle_ignored();
    do_reset();
    put(4'h1, 4'h1, 4'h1, 4'h0, 16'h0000, 1'b0);
    put(4'h0, 4'hF, 4'hF, 4'hF, 16'h1234, 1'b0);
    put(4'h0, 4'h0, 4'hF, 4'h0, 16'hFFFF, 1'b0);
    check("R2 good unchanged", good, 1);
    check("R2 bad unchanged", bad, 0);
    check("R2 bytes unchanged", bytes, 16);
    check("R2 no flags", {v_orph, v_dup, v_gap}, 0);
  endtask

  task automatic t_orphan();
    do_reset();
    put(4'h1, 4'h0, 4'h1, 4'h0, 16'h0000, 1'b0);
    check("R3 orphan flag", v_orph, 1);
    check("R3 not counted good", good, 0);
    check("R3 not counted bytes", bytes, 0);
    check("R3 other flags", {v_dup, v_gap}, 0);
    put(4'h0, 4'h0, 4'h0, 4'h0, 16'h0000, 1'b0);
    check("R6 orphan held", v_orph, 1);
  endtask

  task automatic t_dup_sop();
    do_reset();
    put(4'h3, 4'h3, 4'h2, 4'h0, 16'h0000, 1'b0);
    check("R4 dup flag", v_dup, 1);
    check("R4 one packet", good, 1);
    check("R4 bytes kept", bytes, 32);
    check("R4 no orphan", v_orph, 0);
  endtask

  task automatic t_gap_and_clear();
    do_reset();
    put(4'h2, 4'h2, 4'h2, 4'h0, 16'h0000, 1'b0);
    check("R5 gap flag", v_gap, 1);
    check("R5 still counted", good, 1);
    check("R5 bytes", bytes, 16);
    // clear with a packet in the same cycle: clear wins
    put(4'h1, 4'h1, 4'h1, 4'h1, 16'h0000, 1'b1);
    check("R11 good cleared", good, 0);
    check("R11 bad cleared", bad, 0);
    check("R11 bytes cleared", bytes, 0);
    check("R6 gap survives clear", v_gap, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_four_in_one();
    t_cross_cycle();
    t_err_mask();
    t_idle_ignored();
    t_orphan();
    t_dup_sop();
    t_gap_and_clear();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule